// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block produces the per-beat byte addresses for the memory-mapped sides of a single DMA channel that moves a rectangle of data. A rectangle is a number of rows, each the same number of bytes long. Consecutive rows on one side sit a fixed byte distance apart, called the stride. The source and destination sides each have their own base address and their own stride, so a transfer can reshape a block while it moves it. A row count of one gives an ordinary linear transfer.

Software stages the base addresses, strides and the two length fields, which are both written as count minus one. It then pulses `start`. The block copies every setting on that edge, so new values can be staged for the next transfer while the current one runs. Each memory-mapped side then offers one address per beat with a valid/ready handshake. It marks the last beat of every row and the last beat of the whole transfer. The address outputs also serve as the current-address readback. A side that is built as a streaming peripheral port produces no addresses at all. A one-cycle `done` marks the end of the transfer.

Top module: `dma2d_addr_gen`

## Requirements
- R1: While reset is held and in the first cycle after reset, `src_valid`, `dst_valid`, `busy` and `done` are low.
- R2: A `start` pulse seen while `busy` is low begins a transfer. In the next cycle every memory-mapped side raises its valid and shows that side's base address. Bases, strides and the byte count `x_len_m1`+1 must be multiples of `BEAT_BYTES`.
- R3: Within a row, a side's address rises by `BEAT_BYTES` after each beat accepted with valid and ready both high. While ready is low, the address and flags hold.
- R4: A row has (`x_len_m1`+1)/`BEAT_BYTES` beats. The row-end flag is high exactly on the last beat of each row.
- R5: Each row after the first starts at the previous row's start address plus that side's own stride, taken modulo 2^`ADDR_W`. The source and destination strides act independently.
- R6: A transfer has `y_len_m1`+1 rows, so `y_len_m1`=0 gives a flat transfer. The last flag is high only on the final beat of the final row. Valid drops in the cycle after that beat is accepted.
- R7: A side built as a streaming port (`SRC_MEM` or `DST_MEM` = 0) keeps its valid, address, row-end and last outputs at zero, and it does not delay `done`.
- R8: `busy` is high from the cycle after an accepted start until the final beat of every memory-mapped side has been accepted. `done` is high for exactly the one cycle after that, and a `start` given in that cycle is accepted.
- R9: A `start` given while `busy` is high is ignored. Changes to the configuration inputs after an accepted start do not affect the running transfer.
- R10: Each memory-mapped side advances only on its own handshake. One side may finish while the other has not moved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer with the staged settings |
| src_base | input | ADDR_W | Source start address |
| dst_base | input | ADDR_W | Destination start address |
| x_len_m1 | input | LEN_W | Bytes per row minus one |
| y_len_m1 | input | LEN_W | Row count minus one |
| src_stride | input | ADDR_W | Byte distance between source row starts |
| dst_stride | input | ADDR_W | Byte distance between destination row starts |
| src_ready | input | 1 | Source beat accepted by the memory side |
| src_valid | output | 1 | Source beat address is offered |
| src_addr | output | ADDR_W | Current source beat address |
| src_row_end | output | 1 | Source beat is the last of its row |
| src_last | output | 1 | Source beat is the last of the transfer |
| dst_ready | input | 1 | Destination beat accepted by the memory side |
| dst_valid | output | 1 | Destination beat address is offered |
| dst_addr | output | ADDR_W | Current destination beat address |
| dst_row_end | output | 1 | Destination beat is the last of its row |
| dst_last | output | 1 | Destination beat is the last of the transfer |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse after the final beat |

## Verification
The bench aims at the row turn. If a design added the stride to the current beat address instead of to the row start, it would skip bytes on every row after the first. A negative (wrapping) destination stride and a zero stride show this kind of error, and so does a source stride that differs from the destination's. Single-beat rows and single-row transfers test the flag logic: an off-by-one in the minus-one decoding would give an extra or missing beat, or a last flag on the wrong beat. A start given mid-transfer, with settings changed at the same time, catches a design that reloads while busy or reads its configuration live. Holding one side's ready low while the other runs, and a second instance with a streaming destination, catch a design that couples the sides or waits on a side that never produces addresses. A start in the `done` cycle catches a design that needs an idle gap between transfers.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

   localparam int NUM_SIDES = 2;
   localparam int SIDE_SRC  = 0;
   localparam int SIDE_DST  = 1;

endpackage

// File: rtl/dma2d_span_counter.sv
module dma2d_span_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic         is_zero
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q <= '0;
      else if (load)   cnt_q <= load_val;
      else if (dec)    cnt_q <= cnt_q - W'(1);
   end

   assign is_zero = (cnt_q == '0);
endmodule

// File: rtl/dma2d_side_walker.sv
module dma2d_side_walker #(
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 16,
   parameter int BEAT_BYTES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] stride,
   input  logic [LEN_W-1:0]  beats_m1,
   input  logic [LEN_W-1:0]  rows_m1,
   input  logic              ready,
   output logic              valid,
   output logic [ADDR_W-1:0] addr,
   output logic              row_end,
   output logic              xfer_end
);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BEAT_BYTES);

   logic              active_q;
   logic [ADDR_W-1:0] addr_q, row_q, stride_q;
   logic [LEN_W-1:0]  beats_q;
   logic              col_zero, row_zero;
   logic              fire, wrap, finish, next_row;
   logic [ADDR_W-1:0] next_row_addr;

   assign fire          = active_q & ready;
   assign wrap          = fire & col_zero;
   assign finish        = wrap & row_zero;
   assign next_row      = wrap & ~row_zero;
   assign next_row_addr = row_q + stride_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         addr_q   <= '0;
         row_q    <= '0;
         stride_q <= '0;
         beats_q  <= '0;
      end else if (start) begin
         active_q <= 1'b1;
         addr_q   <= base;
         row_q    <= base;
         stride_q <= stride;
         beats_q  <= beats_m1;
      end else if (fire) begin
         if (finish) begin
            active_q <= 1'b0;
         end else if (next_row) begin
            row_q  <= next_row_addr;
            addr_q <= next_row_addr;
         end else begin
            addr_q <= addr_q + STEP;
         end
      end
   end

   dma2d_span_counter #(.W(LEN_W)) u_col (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (start | next_row),
      .load_val (start ? beats_m1 : beats_q),
      .dec      (fire & ~col_zero),
      .is_zero  (col_zero)
   );

   dma2d_span_counter #(.W(LEN_W)) u_row (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (start),
      .load_val (rows_m1),
      .dec      (next_row),
      .is_zero  (row_zero)
   );

   assign valid    = active_q;
   assign addr     = active_q ? addr_q : '0;
   assign row_end  = active_q & col_zero;
   assign xfer_end = active_q & col_zero & row_zero;
endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen #(
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 16,
   parameter int BEAT_BYTES = 4,
   parameter bit SRC_MEM    = 1'b1,
   parameter bit DST_MEM    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] src_base,
   input  logic [ADDR_W-1:0] dst_base,
   input  logic [LEN_W-1:0]  x_len_m1,
   input  logic [LEN_W-1:0]  y_len_m1,
   input  logic [ADDR_W-1:0] src_stride,
   input  logic [ADDR_W-1:0] dst_stride,
   input  logic              src_ready,
   output logic              src_valid,
   output logic [ADDR_W-1:0] src_addr,
   output logic              src_row_end,
   output logic              src_last,
   input  logic              dst_ready,
   output logic              dst_valid,
   output logic [ADDR_W-1:0] dst_addr,
   output logic              dst_row_end,
   output logic              dst_last,
   output logic              busy,
   output logic              done
);
   import dma2d_pkg::*;

   localparam int BEAT_SHIFT = $clog2(BEAT_BYTES);
   localparam bit [NUM_SIDES-1:0] SIDE_IS_MEM = {DST_MEM, SRC_MEM};

   if (!is_pow2(BEAT_BYTES)) begin : g_bad_beat
      $error("BEAT_BYTES must be a power of two");
   end
   if (!SRC_MEM && !DST_MEM) begin : g_bad_sides
      $error("at least one side must be memory-mapped");
   end
   if (LEN_W > ADDR_W || LEN_W <= BEAT_SHIFT) begin : g_bad_len
      $error("LEN_W must exceed log2(BEAT_BYTES) and not exceed ADDR_W");
   end

   logic [ADDR_W-1:0]    s_base   [NUM_SIDES];
   logic [ADDR_W-1:0]    s_stride [NUM_SIDES];
   logic [ADDR_W-1:0]    s_addr   [NUM_SIDES];
   logic [NUM_SIDES-1:0] s_ready, s_valid, s_row_end, s_last;
   logic [LEN_W-1:0]     beats_m1;
   logic                 start_ok, busy_q;

   assign beats_m1 = x_len_m1 >> BEAT_SHIFT;
   assign start_ok = start & ~busy;

   assign s_base[SIDE_SRC]   = src_base;
   assign s_base[SIDE_DST]   = dst_base;
   assign s_stride[SIDE_SRC] = src_stride;
   assign s_stride[SIDE_DST] = dst_stride;
   assign s_ready            = {dst_ready, src_ready};

   for (genvar g = 0; g < NUM_SIDES; g++) begin : g_side
      if (SIDE_IS_MEM[g]) begin : g_mem
         dma2d_side_walker #(
            .ADDR_W     (ADDR_W),
            .LEN_W      (LEN_W),
            .BEAT_BYTES (BEAT_BYTES)
         ) u_walk (
            .clk      (clk),
            .rst_n    (rst_n),
            .start    (start_ok),
            .base     (s_base[g]),
            .stride   (s_stride[g]),
            .beats_m1 (beats_m1),
            .rows_m1  (y_len_m1),
            .ready    (s_ready[g]),
            .valid    (s_valid[g]),
            .addr     (s_addr[g]),
            .row_end  (s_row_end[g]),
            .xfer_end (s_last[g])
         );
      end else begin : g_stream
         logic unused_side;
         assign unused_side  = ^{s_base[g], s_stride[g], s_ready[g]};
         assign s_valid[g]   = 1'b0;
         assign s_addr[g]    = '0;
         assign s_row_end[g] = 1'b0;
         assign s_last[g]    = 1'b0;
      end
   end

   assign busy = |s_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) busy_q <= 1'b0;
      else        busy_q <= busy;
   end

   assign done = busy_q & ~busy;

   assign src_valid   = s_valid[SIDE_SRC];
   assign src_addr    = s_addr[SIDE_SRC];
   assign src_row_end = s_row_end[SIDE_SRC];
   assign src_last    = s_last[SIDE_SRC];
   assign dst_valid   = s_valid[SIDE_DST];
   assign dst_addr    = s_addr[SIDE_DST];
   assign dst_row_end = s_row_end[SIDE_DST];
   assign dst_last    = s_last[SIDE_DST];
endmodule

// File: rtl/dma2d_addr_gen_chk.sv
module dma2d_addr_gen_chk #(
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 16,
   parameter int BEAT_BYTES = 4,
   parameter bit SRC_MEM    = 1'b1,
   parameter bit DST_MEM    = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [ADDR_W-1:0] src_base,
   input logic [ADDR_W-1:0] dst_base,
   input logic [LEN_W-1:0]  x_len_m1,
   input logic [LEN_W-1:0]  y_len_m1,
   input logic [ADDR_W-1:0] src_stride,
   input logic [ADDR_W-1:0] dst_stride,
   input logic              src_ready,
   input logic              src_valid,
   input logic [ADDR_W-1:0] src_addr,
   input logic              src_row_end,
   input logic              src_last,
   input logic              dst_ready,
   input logic              dst_valid,
   input logic [ADDR_W-1:0] dst_addr,
   input logic              dst_row_end,
   input logic              dst_last,
   input logic              busy,
   input logic              done
);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BEAT_BYTES);

   logic unused_cfg;
   assign unused_cfg = ^{x_len_m1, y_len_m1, src_stride, dst_stride};

   AST_SRC_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      (SRC_MEM && start && !busy) |=> (src_valid && src_addr == $past(src_base)));  // R2
   AST_DST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      (DST_MEM && start && !busy) |=> (dst_valid && dst_addr == $past(dst_base)));  // R2
   AST_SRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (src_valid && !src_ready) |=> (src_valid && $stable(src_addr) && $stable(src_row_end)));  // R3
   AST_DST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (dst_valid && !dst_ready) |=> (dst_valid && $stable(dst_addr) && $stable(dst_row_end)));  // R3
   AST_SRC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (src_valid && src_ready && !src_row_end) |=> (src_valid && src_addr == $past(src_addr) + STEP));  // R3
   AST_DST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (dst_valid && dst_ready && !dst_row_end) |=> (dst_valid && dst_addr == $past(dst_addr) + STEP));  // R3
   AST_SRC_LAST_IN_ROW_END: assert property (@(posedge clk) disable iff (!rst_n)
      src_last |-> src_row_end);  // R6
   AST_SRC_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (src_valid && src_ready && src_last) |=> !src_valid);  // R6
   AST_DST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (dst_valid && dst_ready && dst_last) |=> !dst_valid);  // R6
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !src_valid && !dst_valid));  // R8
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);  // R8
   AST_BUSY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !(src_valid && src_ready && src_last) && !(dst_valid && dst_ready && dst_last))
      |=> busy);  // R9
endmodule

bind dma2d_addr_gen dma2d_addr_gen_chk #(
   .ADDR_W     (ADDR_W),
   .LEN_W      (LEN_W),
   .BEAT_BYTES (BEAT_BYTES),
   .SRC_MEM    (SRC_MEM),
   .DST_MEM    (DST_MEM)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start       (start),
   .src_base    (src_base),
   .dst_base    (dst_base),
   .x_len_m1    (x_len_m1),
   .y_len_m1    (y_len_m1),
   .src_stride  (src_stride),
   .dst_stride  (dst_stride),
   .src_ready   (src_ready),
   .src_valid   (src_valid),
   .src_addr    (src_addr),
   .src_row_end (src_row_end),
   .src_last    (src_last),
   .dst_ready   (dst_ready),
   .dst_valid   (dst_valid),
   .dst_addr    (dst_addr),
   .dst_row_end (dst_row_end),
   .dst_last    (dst_last),
   .busy        (busy),
   .done        (done)
);

// File: tb/sim_dma2d_addr_gen.sv
module sim_dma2d_addr_gen;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;
   localparam int LW = 16;
   localparam int BB = 4;

   typedef logic [AW+1:0] ent_t;  // {last, row_end, addr}

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] src_base = '0, dst_base = '0, src_stride = '0, dst_stride = '0;
   logic [LW-1:0] x_len_m1 = '0, y_len_m1 = '0;
   logic          src_ready = 1'b0, dst_ready = 1'b0;

   logic          sv [2];
   logic          sre[2];
   logic          sl [2];
   logic [AW-1:0] sa [2];
   logic          dv [2];
   logic          dre[2];
   logic          dl [2];
   logic [AW-1:0] da [2];
   logic          bz [2];
   logic          dn [2];

   int   n_chk = 0;
   int   n_fail = 0;
   ent_t qs [2][$];
   ent_t qd [2][$];
   bit   done_e [2];
   bit   req_start = 1'b0;
   int   src_mode = 0;
   int   dst_mode = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dma2d_addr_gen #(.ADDR_W(AW), .LEN_W(LW), .BEAT_BYTES(BB), .SRC_MEM(1'b1), .DST_MEM(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start),
      .src_base(src_base), .dst_base(dst_base), .x_len_m1(x_len_m1), .y_len_m1(y_len_m1),
      .src_stride(src_stride), .dst_stride(dst_stride),
      .src_ready(src_ready), .src_valid(sv[0]), .src_addr(sa[0]), .src_row_end(sre[0]), .src_last(sl[0]),
      .dst_ready(dst_ready), .dst_valid(dv[0]), .dst_addr(da[0]), .dst_row_end(dre[0]), .dst_last(dl[0]),
      .busy(bz[0]), .done(dn[0]));

   // second build: destination is a streaming port (R7)
   dma2d_addr_gen #(.ADDR_W(AW), .LEN_W(LW), .BEAT_BYTES(BB), .SRC_MEM(1'b1), .DST_MEM(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n), .start(start),
      .src_base(src_base), .dst_base(dst_base), .x_len_m1(x_len_m1), .y_len_m1(y_len_m1),
      .src_stride(src_stride), .dst_stride(dst_stride),
      .src_ready(src_ready), .src_valid(sv[1]), .src_addr(sa[1]), .src_row_end(sre[1]), .src_last(sl[1]),
      .dst_ready(dst_ready), .dst_valid(dv[1]), .dst_addr(da[1]), .dst_row_end(dre[1]), .dst_last(dl[1]),
      .busy(bz[1]), .done(dn[1]));

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [AW-1:0] act, input logic [AW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s (u%0s) act=%h exp=%h t=%0t", req, what, "", act, exp, $time);
      end
   endtask

   task automatic check_outputs(input string ph);
      for (int m = 0; m < 2; m++) begin
         bit es = (qs[m].size() != 0);
         bit ed = (qd[m].size() != 0);
         chk(sv[m] == es, "R6", {ph, " src_valid"}, AW'(sv[m]), AW'(es));
         if (es) begin
            chk(sa[m] == qs[m][0][AW-1:0], "R3/R5", {ph, " src_addr"}, sa[m], qs[m][0][AW-1:0]);
            chk(sre[m] == qs[m][0][AW], "R4", {ph, " src_row_end"}, AW'(sre[m]), AW'(qs[m][0][AW]));
            chk(sl[m] == qs[m][0][AW+1], "R6", {ph, " src_last"}, AW'(sl[m]), AW'(qs[m][0][AW+1]));
         end
         if (m == 1) begin
            // R7: streaming side stays silent
            chk(!dv[m] && da[m] == '0 && !dre[m] && !dl[m], "R7", {ph, " stream dst quiet"},
                {dv[m], dre[m], dl[m], da[m][AW-4:0]}, '0);
         end else begin
            chk(dv[m] == ed, "R6", {ph, " dst_valid"}, AW'(dv[m]), AW'(ed));
            if (ed) begin
               chk(da[m] == qd[m][0][AW-1:0], "R3/R5", {ph, " dst_addr"}, da[m], qd[m][0][AW-1:0]);
               chk(dre[m] == qd[m][0][AW], "R4", {ph, " dst_row_end"}, AW'(dre[m]), AW'(qd[m][0][AW]));
               chk(dl[m] == qd[m][0][AW+1], "R6", {ph, " dst_last"}, AW'(dl[m]), AW'(qd[m][0][AW+1]));
            end
         end
         chk(bz[m] == (es || ed), "R8", {ph, " busy"}, AW'(bz[m]), AW'(es || ed));
         chk(dn[m] == done_e[m], "R8", {ph, " done"}, AW'(dn[m]), AW'(done_e[m]));
      end
   endtask

   task automatic load_model(input int m);
      int beats = (int'(x_len_m1) + 1) / BB;
      for (int r = 0; r <= int'(y_len_m1); r++) begin
         logic [AW-1:0] rs_s = src_base + AW'(r) * src_stride;
         logic [AW-1:0] rs_d = dst_base + AW'(r) * dst_stride;
         for (int b = 0; b < beats; b++) begin
            bit re = (b == beats - 1);
            bit la = re && (r == int'(y_len_m1));
            qs[m].push_back({la, re, rs_s + AW'(b * BB)});
            if (m == 0) qd[m].push_back({la, re, rs_d + AW'(b * BB)});
         end
      end
   endtask

   function automatic bit pick(input int mode);
      if (mode == 0) return 1'b1;
      if (mode == 2) return 1'b0;
      return 1'($urandom % 2);
   endfunction

   task automatic step(input string ph);
      @(negedge clk);
      check_outputs(ph);
      src_ready = pick(src_mode);
      dst_ready = pick(dst_mode);
      start     = req_start;
      req_start = 1'b0;
      for (int m = 0; m < 2; m++) begin
         bit was_busy = (qs[m].size() != 0) || (qd[m].size() != 0);
         if (qs[m].size() != 0 && src_ready) void'(qs[m].pop_front());
         if (qd[m].size() != 0 && dst_ready) void'(qd[m].pop_front());
         if (start && !was_busy) load_model(m);  // R9: ignored while busy
         done_e[m] = was_busy && qs[m].size() == 0 && qd[m].size() == 0;
      end
   endtask

   task automatic drain(input string ph);
      int guard = 0;
      while ((qs[0].size() != 0 || qd[0].size() != 0 || qs[1].size() != 0) && guard < 4000) begin
         step(ph);
         guard++;
      end
   endtask

   task automatic launch(input string ph);
      req_start = 1'b1;
      step(ph);
      step("R2 first beat");
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      for (int m = 0; m < 2; m++) begin
         chk(!sv[m] && !dv[m], "R1", "valid in reset", AW'({sv[m], dv[m]}), '0);
         chk(!bz[m] && !dn[m], "R1", "busy/done in reset", AW'({bz[m], dn[m]}), '0);
      end
      rst_n = 1'b1;
      step("R1 after reset");

      // flat transfer, always ready (R6 y=0)
      src_base = 32'h0000_1000; dst_base = 32'h0000_2000;
      x_len_m1 = 16'd15; y_len_m1 = 16'd0; src_stride = '0; dst_stride = '0;
      src_mode = 0; dst_mode = 0;
      launch("R6 flat");
      drain("R6 flat");
      step("R8 done flat");

      // 2D with independent strides and random backpressure (R5)
      src_base = 32'h0001_0000; dst_base = 32'h0002_0000;
      x_len_m1 = 16'd7; y_len_m1 = 16'd2; src_stride = 32'h40; dst_stride = 32'h100;
      src_mode = 1; dst_mode = 1;
      launch("R5 2d");
      drain("R5 2d");
      step("R8 done 2d");

      // single beat rows (R4), negative dst stride wraps (R5)
      src_base = 32'h0000_0100; dst_base = 32'h0000_0010;
      x_len_m1 = 16'd3; y_len_m1 = 16'd3; src_stride = '0; dst_stride = 32'hFFFF_FFF0;
      src_mode = 0; dst_mode = 1;
      launch("R4 single beat rows");
      drain("R4 single beat rows");
      step("R8 done single");

      // R9: start and new settings while busy are ignored
      src_base = 32'h0003_0000; dst_base = 32'h0004_0000;
      x_len_m1 = 16'd7; y_len_m1 = 16'd3; src_stride = 32'h20; dst_stride = 32'h30;
      src_mode = 1; dst_mode = 1;
      launch("R9 base");
      step("R9 run");
      src_base = 32'hDEAD_0000; dst_base = 32'hBEEF_0000; x_len_m1 = 16'd63;
      y_len_m1 = 16'd9; src_stride = 32'h4; dst_stride = 32'h8;
      req_start = 1'b1;
      step("R9 start while busy");
      drain("R9 drain");
      step("R8 done after R9");

      // R10: destination stalled while source runs to its end
      src_base = 32'h0005_0000; dst_base = 32'h0006_0000;
      x_len_m1 = 16'd15; y_len_m1 = 16'd1; src_stride = 32'h80; dst_stride = 32'h200;
      src_mode = 0; dst_mode = 2;
      launch("R10 dst stalled");
      for (int i = 0; i < 15; i++) step("R10 dst stalled");
      chk(dv[0] && da[0] == 32'h0006_0000, "R10", "dst unmoved", da[0], 32'h0006_0000);
      dst_mode = 0;
      drain("R10 drain");
      // R8: start in the done cycle is accepted
      x_len_m1 = 16'd11; y_len_m1 = 16'd1; src_base = 32'h0007_0000; dst_base = 32'h0008_0000;
      src_stride = 32'h10; dst_stride = 32'h0;
      req_start = 1'b1;
      step("R8 start on done");
      step("R2 back-to-back first beat");
      chk(sv[0] && sa[0] == 32'h0007_0000, "R8", "back-to-back start", sa[0], 32'h0007_0000);
      src_mode = 1; dst_mode = 1;
      drain("R8 back-to-back");
      step("R8 done final");

      // long rows, two rows
      src_base = 32'h0009_0000; dst_base = 32'h000A_0000;
      x_len_m1 = 16'd31; y_len_m1 = 16'd1; src_stride = 32'h24; dst_stride = 32'h40;
      launch("R4 long rows");
      drain("R4 long rows");
      step("R8 done long");
      step("R1 idle");

      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule